// File: doc/BRIEF.md
# Prioritized Interrupt Controller

This block collects sixteen single-cycle interrupt event pulses and turns them into one prioritized request for a CPU. Every source has a latched pending flag and an enable bit. The sources fall into seven fixed groups, and each group carries a two-bit priority level that software programs. A small register bus with an address, write data, a write strobe and combinational read data gives access to the flags, the enables and the priority fields.

The output shows the level of the highest-priority pending group, whether that level exceeds the CPU's current mask level, which group won, and which source inside that group is the lowest-numbered one pending. A source stays pending until software clears its flag, so a handler that returns without clearing the flag is interrupted again. The request outputs are registered.

Source-to-group assignment in bit order: sources 0–1 form group 0, source 2 is group 1, sources 3–4 are group 2, sources 5–7 are group 3, sources 8–10 are group 4, sources 11–14 are group 5, and source 15 is group 6.

Top module: `prio_irq_ctrl`

## Requirements
- R1: After reset, all flags, enables and priority fields read as 0, and irqReq, irqLevel, irqGroup and irqSource are all 0.
- R2: A pulse on srcEvent bit n sets flag n, and the flag stays set until software clears it.
- R3: A write to address 0 clears every flag whose write-data bit is 1. Flags whose write-data bit is 0 are left unchanged. A read of address 0 returns the flags in bits 15:0.
- R4: If an event and a write-1 clear hit the same flag in the same cycle, the flag ends up set.
- R5: A write to address 1 loads the enable bits, bit n enabling source n, and a read of address 1 returns them. A read of address 3 returns 0.
- R6: A group is pending only when at least one of its sources has both its flag and its enable set.
- R7: A write to address 2 loads the priority fields. Group g uses bits 2g+1:2g, giving levels 0 to 3, and a read returns them in bits 13:0 with bits 15:14 read as 0. A group at level 0 never wins.
- R8: irqLevel is the highest level among pending groups whose level is nonzero, or 0 when there is none. irqGroup is the index of that group, and among groups with equal level the lower index wins. irqGroup is 0 when no group wins.
- R9: irqSource is the lowest-numbered source in the winning group that has both its flag and its enable set. It is 0 when no group wins.
- R10: irqReq is 1 only when irqLevel is greater than cpuMask.
- R11: The outputs reflect the flags, enables, priorities and cpuMask as they stood before the previous rising clock edge, giving one cycle of latency.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous reset, active low |
| srcEvent | input | 16 | Single-cycle event pulses, one bit per source |
| busAddr | input | 2 | Register address: 0 flags, 1 enables, 2 priorities |
| busWdata | input | 16 | Write data |
| busWe | input | 1 | Write strobe |
| busRdata | output | 16 | Combinational read data for busAddr |
| cpuMask | input | 2 | CPU's current interrupt mask level |
| irqReq | output | 1 | Request asserted to the CPU |
| irqLevel | output | 2 | Level of the winning group |
| irqGroup | output | 3 | Index of the winning group |
| irqSource | output | 4 | Index of the reported source |

## Verification
A source event and a software write-1 clear can land on the same flag in the same clock cycle. The block must let the set win, so that the event is not lost. The bench arranges this case on purpose with a clear of bit 0 during an event on bit 0. The random traffic also brings it about often, by mixing sparse event pulses with writes to address 0 that carry random data. In each case the bench judges the outcome by reading the flag back and by watching the winning group and source follow a reference model in which the set wins.

// File: rtl/irq_pkg.sv
`timescale 1ns/1ps
package irq_pkg;
  typedef struct packed {
    logic wrFlag;
    logic wrEnable;
    logic wrPrio;
  } regStrobe_t;

  localparam int ADDR_FLAG   = 0;
  localparam int ADDR_ENABLE = 1;
  localparam int ADDR_PRIO   = 2;
  localparam int LVL_W       = 2;
endpackage

// File: rtl/irq_bus_ctrl.sv
`timescale 1ns/1ps
module irq_bus_ctrl
  import irq_pkg::*;
#(
  parameter int ADDR_W = 2
) (
  input  logic [ADDR_W-1:0] busAddr,
  input  logic              busWe,
  output regStrobe_t        strobe
);
  always_comb begin
    strobe.wrFlag   = busWe && (busAddr == ADDR_W'(ADDR_FLAG));
    strobe.wrEnable = busWe && (busAddr == ADDR_W'(ADDR_ENABLE));
    strobe.wrPrio   = busWe && (busAddr == ADDR_W'(ADDR_PRIO));
  end

  always_comb begin
    assert_strobe_onehot_R5: assert ($onehot0(strobe));
  end
endmodule

// File: rtl/irq_regfile.sv
`timescale 1ns/1ps
module irq_regfile
  import irq_pkg::*;
#(
  parameter int NUM_SRC = 16,
  parameter int NUM_GRP = 7,
  parameter int DATA_W  = 16,
  parameter int ADDR_W  = 2,
  localparam int PRIO_W = LVL_W * NUM_GRP
) (
  input  logic                clk,
  input  logic                rstN,
  input  regStrobe_t          strobe,
  input  logic [ADDR_W-1:0]   busAddr,
  input  logic [DATA_W-1:0]   busWdata,
  input  logic [NUM_SRC-1:0]  srcEvent,
  output logic [NUM_SRC-1:0]  flagReg,
  output logic [NUM_SRC-1:0]  enReg,
  output logic [PRIO_W-1:0]   prioReg,
  output logic [DATA_W-1:0]   busRdata
);
  logic [NUM_SRC-1:0] wdSrc;
  logic [NUM_SRC-1:0] clrMask;

  assign wdSrc   = busWdata[NUM_SRC-1:0];
  assign clrMask = strobe.wrFlag ? wdSrc : '0;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      flagReg <= '0;
      enReg   <= '0;
      prioReg <= '0;
    end else begin
      flagReg <= (flagReg & ~clrMask) | srcEvent;
      if (strobe.wrEnable) enReg <= wdSrc;
      if (strobe.wrPrio)   prioReg <= busWdata[PRIO_W-1:0];
    end
  end

  always_comb begin
    case (busAddr)
      ADDR_W'(ADDR_FLAG):   busRdata = DATA_W'(flagReg);
      ADDR_W'(ADDR_ENABLE): busRdata = DATA_W'(enReg);
      ADDR_W'(ADDR_PRIO):   busRdata = DATA_W'(prioReg);
      default:              busRdata = '0;
    endcase
  end

  assert_event_sets_R2: assert property (@(posedge clk) disable iff (!rstN)
    (|srcEvent) |=> ((flagReg & $past(srcEvent)) == $past(srcEvent)));
  assert_w1c_clears_R3: assert property (@(posedge clk) disable iff (!rstN)
    strobe.wrFlag |=> ((flagReg & $past(wdSrc & ~srcEvent)) == '0));
  assert_flag_holds_R3: assert property (@(posedge clk) disable iff (!rstN)
    !strobe.wrFlag |=> ((flagReg & $past(flagReg)) == $past(flagReg)));
  assert_set_wins_R4: assert property (@(posedge clk) disable iff (!rstN)
    (strobe.wrFlag && ((wdSrc & srcEvent) != '0)) |=>
      ((flagReg & $past(wdSrc & srcEvent)) == $past(wdSrc & srcEvent)));
  assert_enable_load_R5: assert property (@(posedge clk) disable iff (!rstN)
    strobe.wrEnable |=> (enReg == $past(wdSrc)));
endmodule

// File: rtl/irq_arbiter.sv
`timescale 1ns/1ps
module irq_arbiter
  import irq_pkg::*;
#(
  parameter int NUM_SRC = 16,
  parameter int NUM_GRP = 7,
  parameter int GRP_SIZE [NUM_GRP] = '{2, 1, 2, 3, 3, 4, 1},
  localparam int PRIO_W = LVL_W * NUM_GRP,
  localparam int GRP_W  = (NUM_GRP > 1) ? $clog2(NUM_GRP) : 1,
  localparam int SRC_W  = (NUM_SRC > 1) ? $clog2(NUM_SRC) : 1
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic [NUM_SRC-1:0] flagReg,
  input  logic [NUM_SRC-1:0] enReg,
  input  logic [PRIO_W-1:0]  prioReg,
  input  logic [LVL_W-1:0]   cpuMask,
  output logic               irqReq,
  output logic [LVL_W-1:0]   irqLevel,
  output logic [GRP_W-1:0]   irqGroup,
  output logic [SRC_W-1:0]   irqSource
);
  function automatic logic [NUM_SRC-1:0] memberMask(int g);
    int first;
    logic [NUM_SRC-1:0] m;
    first = 0;
    for (int k = 0; k < g; k++) first += GRP_SIZE[k];
    m = '0;
    for (int s = 0; s < NUM_SRC; s++)
      if (s >= first && s < first + GRP_SIZE[g]) m[s] = 1'b1;
    return m;
  endfunction

  logic [NUM_SRC-1:0] active;
  logic [NUM_GRP-1:0] pendGrp;
  logic [LVL_W-1:0]   grpLvl [NUM_GRP];
  logic [SRC_W-1:0]   grpSrc [NUM_GRP];

  assign active = flagReg & enReg;

  for (genvar g = 0; g < NUM_GRP; g++) begin : gGroup
    localparam logic [NUM_SRC-1:0] MEMBERS = memberMask(g);
    logic [NUM_SRC-1:0] hits;
    assign hits      = active & MEMBERS;
    assign pendGrp[g] = |hits;
    assign grpLvl[g]  = prioReg[LVL_W*g +: LVL_W];
    always_comb begin
      grpSrc[g] = '0;
      for (int s = NUM_SRC - 1; s >= 0; s--)
        if (hits[s]) grpSrc[g] = SRC_W'(s);
    end
  end

  logic [LVL_W-1:0] bestLvl;
  logic [GRP_W-1:0] bestGrp;
  logic [SRC_W-1:0] bestSrc;

  always_comb begin
    bestLvl = '0;
    bestGrp = '0;
    bestSrc = '0;
    for (int g = NUM_GRP - 1; g >= 0; g--) begin
      if (pendGrp[g] && grpLvl[g] != '0 && grpLvl[g] >= bestLvl) begin
        bestLvl = grpLvl[g];
        bestGrp = GRP_W'(g);
        bestSrc = grpSrc[g];
      end
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      irqReq    <= 1'b0;
      irqLevel  <= '0;
      irqGroup  <= '0;
      irqSource <= '0;
    end else begin
      irqReq    <= bestLvl > cpuMask;
      irqLevel  <= bestLvl;
      irqGroup  <= bestGrp;
      irqSource <= bestSrc;
    end
  end

  assert_winner_pending_R6: assert property (@(posedge clk) disable iff (!rstN)
    (irqLevel != '0) |-> ((($past(pendGrp) >> irqGroup) & 1) == 1));
  assert_level_matches_R8: assert property (@(posedge clk) disable iff (!rstN)
    (irqLevel != '0) |-> (irqLevel == LVL_W'($past(prioReg) >> (LVL_W * irqGroup))));
  assert_source_active_R9: assert property (@(posedge clk) disable iff (!rstN)
    (irqLevel != '0) |-> ((($past(active) >> irqSource) & 1) == 1));
  assert_req_above_mask_R10: assert property (@(posedge clk) disable iff (!rstN)
    irqReq |-> (irqLevel > $past(cpuMask)));
  assert_zero_level_quiet_R7: assert property (@(posedge clk) disable iff (!rstN)
    (irqLevel == '0) |-> !irqReq);
endmodule

// File: rtl/prio_irq_ctrl.sv
`timescale 1ns/1ps
module prio_irq_ctrl
  import irq_pkg::*;
#(
  parameter int NUM_SRC = 16,
  parameter int NUM_GRP = 7,
  parameter int DATA_W  = 16,
  parameter int ADDR_W  = 2,
  parameter int GRP_SIZE [NUM_GRP] = '{2, 1, 2, 3, 3, 4, 1},
  localparam int PRIO_W = LVL_W * NUM_GRP,
  localparam int GRP_W  = (NUM_GRP > 1) ? $clog2(NUM_GRP) : 1,
  localparam int SRC_W  = (NUM_SRC > 1) ? $clog2(NUM_SRC) : 1
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic [NUM_SRC-1:0] srcEvent,
  input  logic [ADDR_W-1:0]  busAddr,
  input  logic [DATA_W-1:0]  busWdata,
  input  logic               busWe,
  output logic [DATA_W-1:0]  busRdata,
  input  logic [LVL_W-1:0]   cpuMask,
  output logic               irqReq,
  output logic [LVL_W-1:0]   irqLevel,
  output logic [GRP_W-1:0]   irqGroup,
  output logic [SRC_W-1:0]   irqSource
);
  regStrobe_t         strobe;
  logic [NUM_SRC-1:0] flagReg;
  logic [NUM_SRC-1:0] enReg;
  logic [PRIO_W-1:0]  prioReg;

  irq_bus_ctrl #(.ADDR_W(ADDR_W)) uCtrl (
    .busAddr(busAddr), .busWe(busWe), .strobe(strobe)
  );

  irq_regfile #(.NUM_SRC(NUM_SRC), .NUM_GRP(NUM_GRP), .DATA_W(DATA_W),
                .ADDR_W(ADDR_W)) uRegs (
    .clk(clk), .rstN(rstN), .strobe(strobe), .busAddr(busAddr),
    .busWdata(busWdata), .srcEvent(srcEvent), .flagReg(flagReg),
    .enReg(enReg), .prioReg(prioReg), .busRdata(busRdata)
  );

  irq_arbiter #(.NUM_SRC(NUM_SRC), .NUM_GRP(NUM_GRP),
                .GRP_SIZE(GRP_SIZE)) uArb (
    .clk(clk), .rstN(rstN), .flagReg(flagReg), .enReg(enReg),
    .prioReg(prioReg), .cpuMask(cpuMask), .irqReq(irqReq),
    .irqLevel(irqLevel), .irqGroup(irqGroup), .irqSource(irqSource)
  );
endmodule

// File: tb/sim_prio_irq_ctrl.sv
`timescale 1ns/1ps
module sim_prio_irq_ctrl;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic [15:0] srcEvent = '0;
  logic [1:0]  busAddr = '0;
  logic [15:0] busWdata = '0;
  logic        busWe = 1'b0;
  logic [15:0] busRdata;
  logic [1:0]  cpuMask = '0;
  logic        irqReq;
  logic [1:0]  irqLevel;
  logic [2:0]  irqGroup;
  logic [3:0]  irqSource;

  int nChecks = 0;
  int nFails = 0;
  bit done = 1'b0;

  logic [15:0] mFlag = '0;
  logic [15:0] mEn = '0;
  logic [13:0] mPrio = '0;

  always #10 clk = ~clk;

  prio_irq_ctrl u0 (
    .clk(clk), .rstN(rstN), .srcEvent(srcEvent), .busAddr(busAddr),
    .busWdata(busWdata), .busWe(busWe), .busRdata(busRdata),
    .cpuMask(cpuMask), .irqReq(irqReq), .irqLevel(irqLevel),
    .irqGroup(irqGroup), .irqSource(irqSource)
  );

  function automatic int grpOf(int s);
    if (s < 2) return 0;
    if (s < 3) return 1;
    if (s < 5) return 2;
    if (s < 8) return 3;
    if (s < 11) return 4;
    if (s < 15) return 5;
    return 6;
  endfunction

  // packed expectation: {req, level[1:0], group[2:0], source[3:0]}
  function automatic logic [9:0] expOut(logic [15:0] f, logic [15:0] e,
                                        logic [13:0] p, logic [1:0] m);
    logic [15:0] act;
    int win, best, src;
    act = f & e;
    win = 0; best = 0; src = 0;
    for (int g = 0; g < 7; g++) begin
      bit pend;
      int lv;
      pend = 1'b0;
      lv = int'(p[2*g +: 2]);
      for (int s = 0; s < 16; s++) if (act[s] && grpOf(s) == g) pend = 1'b1;
      if (pend && lv > best) begin best = lv; win = g; end
    end
    if (best != 0)
      for (int s = 15; s >= 0; s--) if (act[s] && grpOf(s) == win) src = s;
    return {(best > int'(m)), 2'(best), 3'(win), 4'(src)};
  endfunction

  function automatic logic [15:0] expRead(logic [1:0] a);
    case (a)
      2'd0: return mFlag;
      2'd1: return mEn;
      2'd2: return {2'b00, mPrio};
      default: return 16'h0000;
    endcase
  endfunction

  task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
    nChecks++;
    if (act !== exp) begin
      nFails++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  // Called at a falling edge. Applies one cycle of stimulus and checks both
  // the combinational read and the registered outputs one edge later.
  task automatic step(logic [15:0] ev, logic we, logic [1:0] a,
                      logic [15:0] wd, logic [1:0] m);
    logic [9:0] e;
    string rtag;
    srcEvent = ev; busWe = we; busAddr = a; busWdata = wd; cpuMask = m;
    #1;
    rtag = (a == 2'd0) ? "R3 flag read" : (a == 2'd1) ? "R5 enable read" :
           (a == 2'd2) ? "R7 prio read" : "R5 unmapped read";
    chk(rtag, 32'(busRdata), 32'(expRead(a)));
    e = expOut(mFlag, mEn, mPrio, m);
    if (we && a == 2'd0) mFlag = mFlag & ~wd;
    mFlag = mFlag | ev;
    if (we && a == 2'd1) mEn = wd;
    if (we && a == 2'd2) mPrio = wd[13:0];
    @(posedge clk);
    @(negedge clk);
    chk("R10 irqReq", 32'(irqReq), 32'(e[9]));
    chk("R8 irqLevel", 32'(irqLevel), 32'(e[8:7]));
    chk("R8 irqGroup", 32'(irqGroup), 32'(e[6:4]));
    chk("R9 irqSource", 32'(irqSource), 32'(e[3:0]));
  endtask

  task automatic idle(logic [1:0] a, logic [1:0] m);
    step(16'h0, 1'b0, a, 16'h0, m);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      nFails++;
      nChecks++;
      $display("FAIL watchdog expired");
      $display("== %0d vectors applied, %0d miscompares ==", nChecks, nFails);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd4711));
    repeat (3) @(negedge clk);
    // R1: reset state of outputs and all registers
    chk("R1 irqReq", 32'(irqReq), 0);
    chk("R1 irqLevel", 32'(irqLevel), 0);
    chk("R1 irqGroup", 32'(irqGroup), 0);
    chk("R1 irqSource", 32'(irqSource), 0);
    rstN = 1'b1;
    @(negedge clk);
    for (int a = 0; a < 4; a++) begin
      busAddr = 2'(a); #1;
      chk("R1 register read", 32'(busRdata), 0);
    end

    // event with nothing enabled: flag set (R2) but no group pending (R6)
    step(16'h0008, 1'b0, 2'd0, 16'h0, 2'd0);
    idle(2'd0, 2'd0);
    chk("R2 flag latched", 32'(busRdata), 32'h0008);
    chk("R6 disabled source silent", 32'(irqLevel), 0);
    step(16'h0, 1'b1, 2'd1, 16'hFFFF, 2'd0);
    // all enabled but every level still 0: R7 level 0 never wins
    idle(2'd1, 2'd0);
    chk("R7 level zero quiet", 32'(irqLevel), 0);
    step(16'h0, 1'b1, 2'd2, 16'h1555, 2'd0);
    // R11: the cycle right after the priority write still shows no request
    chk("R11 latency", 32'(irqReq), 0);
    idle(2'd2, 2'd0);
    chk("R11 request after one edge", 32'(irqReq), 1);
    chk("R9 source 3", 32'(irqSource), 3);

    // equal levels: lower group index wins (R8)
    step(16'h8800, 1'b0, 2'd0, 16'h0, 2'd0);
    idle(2'd0, 2'd0);
    chk("R8 tie to group 2", 32'(irqGroup), 2);
    step(16'h0, 1'b1, 2'd0, 16'h0008, 2'd0);
    idle(2'd0, 2'd0);
    chk("R8 tie to group 5", 32'(irqGroup), 5);
    chk("R9 source 11", 32'(irqSource), 11);
    step(16'h0, 1'b1, 2'd2, 16'h3555, 2'd0);
    idle(2'd2, 2'd0);
    chk("R8 higher level wins", 32'(irqGroup), 6);
    // R10: mask equal to level blocks the request
    idle(2'd0, 2'd3);
    idle(2'd0, 2'd3);
    chk("R10 masked", 32'(irqReq), 0);
    chk("R10 level still shown", 32'(irqLevel), 3);

    // R4: event and clear on bit 0 in the same cycle
    step(16'h0001, 1'b1, 2'd0, 16'h0001, 2'd0);
    idle(2'd0, 2'd0);
    chk("R4 set wins", 32'(busRdata[0]), 1);
    // R3: writing zeros changes nothing
    step(16'h0, 1'b1, 2'd0, 16'h0000, 2'd0);
    idle(2'd0, 2'd0);
    chk("R3 zero write ignored", 32'(busRdata), 32'h8801);

    for (int i = 0; i < 4000; i++) begin
      logic [15:0] ev;
      logic we;
      ev = 16'($urandom & $urandom & $urandom);
      we = ($urandom % 3) == 0;
      step(ev, we, 2'($urandom), 16'($urandom), 2'($urandom));
    end

    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", nChecks, nFails);
    $finish;
  end
endmodule